// File: doc/BRIEF.md
# Double-Buffered Fine-Resolution PWM Generator

This block drives one pulse-width modulated output from a period counter that is stretched by two low-order sub-count bits. The duty value therefore has two more bits of resolution than the period register. The 8-bit period timer plus the 2 sub-count bits form a 10-bit time base. A selectable prescaler slows that time base down by a factor of 1, 4 or 16. Software writes a period byte, a duty high byte, and a control byte through a small synchronous write port. The control byte holds the two duty low bits and the enable bit.

The duty value is double-buffered. Software writes only the buffered copy. An internal active copy takes that value at each period boundary and is driven out on a read-back port. A new duty setting therefore never cuts a pulse short or stretches it.

The output rises at the start of every period unless the active duty is zero. It falls when the 10-bit time base reaches the active duty. While the enable bit is clear, the counters are held at zero and the output is driven low.

Top module: `pwm_fine`

## Requirements
- R1: After reset, `pwm_o` is 0, `duty_active_o` is 0, and the block is disabled.
- R2: Let p be the prescale factor. While enabled, the period is (P+1)·4·p clocks, where P is the period register. The first period after enabling is spent low, and the output first rises (P+1)·4·p clocks after the enabling write lands.
- R3: `psel` selects the prescale factor: 2'b00 gives 1, 2'b01 gives 4, and 2'b10 or 2'b11 gives 16. The sub-count advances once every p clocks.
- R4: The duty is D = {duty high byte, control bits [1:0]}. When 0 < D < (P+1)·4, the output is high for exactly D·p clocks at the start of each period.
- R5: When the active duty is 0, the output is not set at the period boundary and stays low for the whole period.
- R6: When the active duty is at least (P+1)·4, the output stays high for the whole period.
- R7: Duty writes land in the buffer at any time. `duty_active_o` and the pulse width change only at a period boundary, where the buffer is copied into the active register.
- R8: Writing the control byte with bit 2 clear forces `pwm_o` low from the second clock edge after the write, and holds the time base at 0. Setting bit 2 again restarts the time base from 0.
- R9: Write address map: 0 is the period, 1 is the duty high byte, and 2 is the control byte (bit 2 enable, bits [1:0] duty low bits). Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| psel | input | 2 | Prescale select |
| pwm_o | output | 1 | PWM output |
| duty_active_o | output | 10 | Active (shadow) duty value, read-only |

## Verification
A register write lands at the clock edge that samples it. The output register responds one edge later: the first rise comes (P+1)·4·p clocks after the enabling edge, and a disable shows on `pwm_o` from the second edge after the write. The bench keeps a cycle counter and a buffered/active duty model that advance once per clock and that apply the boundary copy before a same-edge write. It compares `pwm_o` and `duty_active_o` at every falling edge against values derived arithmetically from the period, duty and prescale. Period length is also measured between successive rising edges for every prescale code.

// File: rtl/pwm_fine_pkg.sv
`timescale 1ns/1ps
package pwm_fine_pkg;
   typedef enum logic [1:0] {
      ADDR_PERIOD  = 2'd0,
      ADDR_DUTY_HI = 2'd1,
      ADDR_CTRL    = 2'd2,
      ADDR_SPARE   = 2'd3
   } pwm_addr_e;

   localparam int SUB_BITS = 2;
endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
   import pwm_fine_pkg::*;
#(
   parameter int TMR_W = 8,
   parameter int SUB_W = 2,
   localparam int DUTY_W = TMR_W + SUB_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [TMR_W-1:0]  wr_data,
   output logic [TMR_W-1:0]  period_q,
   output logic [DUTY_W-1:0] duty_buf_q,
   output logic              en_q
);
   localparam int EN_BIT = SUB_W;

   generate
      if (TMR_W <= SUB_W) begin : g_bad_width
         $error("pwm_regs: TMR_W must exceed SUB_W to hold the enable bit");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q   <= '0;
         duty_buf_q <= '0;
         en_q       <= 1'b0;
      end else if (wr_en) begin
         case (pwm_addr_e'(wr_addr))
            ADDR_PERIOD:  period_q <= wr_data;
            ADDR_DUTY_HI: duty_buf_q[DUTY_W-1:SUB_W] <= wr_data;
            ADDR_CTRL: begin
               duty_buf_q[SUB_W-1:0] <= wr_data[SUB_W-1:0];
               en_q                  <= wr_data[EN_BIT];
            end
            default: ;
         endcase
      end
   end

   // R9: the spare address leaves every register untouched
   p_spare_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd3) |=> $stable({period_q, duty_buf_q, en_q}));
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase #(
   parameter int TMR_W     = 8,
   parameter int SUB_W     = 2,
   parameter int PSC_SHIFT = 2,
   localparam int DUTY_W = TMR_W + SUB_W,
   localparam int DIV_W  = (2 * PSC_SHIFT > 0) ? 2 * PSC_SHIFT : 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [1:0]        psel,
   input  logic [TMR_W-1:0]  period,
   output logic [DUTY_W-1:0] base,
   output logic [DUTY_W-1:0] base_nxt,
   output logic              adv,
   output logic              roll
);
   logic [TMR_W-1:0] tmr_q;
   logic [SUB_W-1:0] sub_q;
   logic             tick;

   generate
      if (PSC_SHIFT == 0) begin : g_no_div
         assign adv = en;
         logic unused_psel;
         assign unused_psel = ^psel;
      end else begin : g_div
         logic [DIV_W-1:0] div_q;
         logic [DIV_W-1:0] lim;
         logic             div_last;

         always_comb begin
            case (psel)
               2'd0:    lim = '0;
               2'd1:    lim = DIV_W'((1 << PSC_SHIFT) - 1);
               default: lim = '1;
            endcase
         end

         assign div_last = (div_q >= lim);
         assign adv      = en & div_last;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        div_q <= '0;
            else if (!en)      div_q <= '0;
            else if (div_last) div_q <= '0;
            else               div_q <= div_q + 1'b1;
         end
      end
   endgenerate

   assign tick     = adv & (&sub_q);
   assign roll     = tick & (tmr_q == period);
   assign base     = {tmr_q, sub_q};
   assign base_nxt = roll ? '0 : (adv ? base + 1'b1 : base);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q <= '0;
         sub_q <= '0;
      end else if (!en) begin
         tmr_q <= '0;
         sub_q <= '0;
      end else begin
         if (adv)  sub_q <= sub_q + 1'b1;
         if (tick) tmr_q <= roll ? '0 : tmr_q + 1'b1;
      end
   end

   // R3: the sub-count only moves on a prescaler advance
   p_sub_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !adv) |=> $stable(sub_q));
   // R2: a period end restarts the time base at zero
   p_roll_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      roll |=> (base == '0));
endmodule

// File: rtl/pwm_duty_shadow.sv
`timescale 1ns/1ps
module pwm_duty_shadow #(
   parameter int DUTY_W = 10
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              roll,
   input  logic [DUTY_W-1:0] duty_buf,
   output logic [DUTY_W-1:0] active_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    active_q <= '0;
      else if (roll) active_q <= duty_buf;
   end

   // R7: the active duty changes only at a period boundary
   p_active_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !roll |=> $stable(active_q));
endmodule

// File: rtl/pwm_out_latch.sv
`timescale 1ns/1ps
module pwm_out_latch #(
   parameter int DUTY_W = 10
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              roll,
   input  logic              adv,
   input  logic [DUTY_W-1:0] base_nxt,
   input  logic [DUTY_W-1:0] duty_buf,
   input  logic [DUTY_W-1:0] active,
   output logic              out_q
);
   logic set_ok;
   logic hit;

   assign set_ok = (duty_buf != '0);
   assign hit    = adv && (base_nxt == active);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    out_q <= 1'b0;
      else if (!en)  out_q <= 1'b0;
      else if (roll) out_q <= set_ok;
      else if (hit)  out_q <= 1'b0;
   end

   // R8: a disabled block drives the output low
   p_disable_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !out_q);
   // R5: a zero duty suppresses the set at the boundary
   p_zero_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (roll && duty_buf == '0) |=> !out_q);
   // R2: the output rises only at a period boundary
   p_rise_at_roll_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !roll |=> !$rose(out_q));
endmodule

// File: rtl/pwm_fine.sv
`timescale 1ns/1ps
module pwm_fine
   import pwm_fine_pkg::*;
#(
   parameter int TMR_W     = 8,
   parameter int PSC_SHIFT = 2,
   localparam int SUB_W  = SUB_BITS,
   localparam int DUTY_W = TMR_W + SUB_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [TMR_W-1:0]  wr_data,
   input  logic [1:0]        psel,
   output logic              pwm_o,
   output logic [DUTY_W-1:0] duty_active_o
);
   logic [TMR_W-1:0]  period_q;
   logic [DUTY_W-1:0] duty_buf_q;
   logic              en_q;
   logic [DUTY_W-1:0] base;
   logic [DUTY_W-1:0] base_nxt;
   logic              adv;
   logic              roll;

   generate
      if (PSC_SHIFT > 4) begin : g_bad_psc
         $error("pwm_fine: PSC_SHIFT above 4 is not supported");
      end
   endgenerate

   pwm_regs #(.TMR_W(TMR_W), .SUB_W(SUB_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .period_q(period_q), .duty_buf_q(duty_buf_q),
      .en_q(en_q)
   );

   pwm_timebase #(.TMR_W(TMR_W), .SUB_W(SUB_W), .PSC_SHIFT(PSC_SHIFT)) i_tb (
      .clk(clk), .rst_n(rst_n), .en(en_q), .psel(psel), .period(period_q),
      .base(base), .base_nxt(base_nxt), .adv(adv), .roll(roll)
   );

   pwm_duty_shadow #(.DUTY_W(DUTY_W)) i_shadow (
      .clk(clk), .rst_n(rst_n), .roll(roll), .duty_buf(duty_buf_q),
      .active_q(duty_active_o)
   );

   pwm_out_latch #(.DUTY_W(DUTY_W)) i_out (
      .clk(clk), .rst_n(rst_n), .en(en_q), .roll(roll), .adv(adv),
      .base_nxt(base_nxt), .duty_buf(duty_buf_q), .active(duty_active_o),
      .out_q(pwm_o)
   );

   logic unused_base;
   assign unused_base = ^base;

   // R1: leaving reset the output is low and the active duty is zero
   p_reset_state_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> (!pwm_o && duty_active_o == '0));
endmodule

// File: tb/test_pwm_fine.sv
`timescale 1ns/1ps
module test_pwm_fine;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] psel = '0;
   logic       pwm_o;
   logic [9:0] duty_active_o;

   int  checks = 0;
   int  errors = 0;
   bit  done = 0;
   // bench model
   int  m_t = 0, m_act = 0, m_buf = 0, m_pr = 0;
   bit  m_en = 0, m_stop = 0, m_ctrl_en = 0;
   bit  smp = 0;

   always #10 clk = ~clk;

   pwm_fine i_pwm_fine (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .psel(psel), .pwm_o(pwm_o),
      .duty_active_o(duty_active_o)
   );

   function automatic int fac(input logic [1:0] s);
      return (s == 2'd0) ? 1 : ((s == 2'd1) ? 4 : 16);
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // one clock: check this cycle, drive the next write, advance the model
   task automatic tick(input bit we, input logic [1:0] a, input logic [7:0] d, input string tag);
      int p, ph, exp_o;
      @(negedge clk);
      p = (m_pr + 1) * 4 * fac(psel);
      exp_o = 0;
      if (m_en && m_t >= p) begin
         ph = (m_t - p) % p;
         exp_o = (m_act != 0 && ph < m_act * fac(psel)) ? 1 : 0;
      end
      smp = pwm_o;
      check(tag, "pwm_o", int'(pwm_o), exp_o);
      check(tag, "duty_active_o", int'(duty_active_o), m_act);
      wr_en = we; wr_addr = a; wr_data = d;
      if (m_stop) begin
         m_en = 0; m_stop = 0;
      end else if (m_en) begin
         m_t++;
         if (m_t >= p && (m_t - p) % p == 0) m_act = m_buf;
      end
      if (we) begin
         case (a)
            2'd0: m_pr = int'(d);
            2'd1: m_buf = (int'(d) << 2) | (m_buf & 3);
            2'd2: begin
               m_buf = (m_buf & ~3) | (int'(d) & 3);
               if (d[2] && !m_ctrl_en) begin m_en = 1; m_t = 0; end
               else if (!d[2] && m_ctrl_en) m_stop = 1;
               m_ctrl_en = d[2];
            end
            default: ;
         endcase
      end
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) tick(0, 2'd0, 8'd0, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int duties[6];
      int prs[3];
      prs = '{0, 1, 3};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "pwm_o after reset", int'(pwm_o), 0);
      check("R1", "duty_active_o after reset", int'(duty_active_o), 0);
      idle(4, "R1");

      // sweep prescale, period and duty (R2..R6, R8)
      for (int s = 0; s < 4; s++) begin
         for (int k = 0; k < 3; k++) begin
            int pr, ratio, p;
            pr = prs[k];
            ratio = (pr + 1) * 4;
            duties = '{0, 1, 2, ratio - 1, ratio, 1023};
            for (int j = 0; j < 6; j++) begin
               int dv, last_rise;
               bit prev;
               string tag;
               dv = duties[j];
               tag = (dv == 0) ? "R5" : ((dv >= ratio) ? "R6" : "R4");
               psel = 2'(s);
               tick(1, 2'd0, 8'(pr), tag);
               tick(1, 2'd1, 8'(dv >> 2), tag);
               tick(1, 2'd2, 8'(dv & 3), tag);
               tick(1, 2'd2, 8'(4 | (dv & 3)), tag);
               p = ratio * fac(psel);
               last_rise = -1;
               prev = 0;
               for (int i = 0; i < 3 * p + 2; i++) begin
                  tick(0, 2'd0, 8'd0, tag);
                  if (smp && !prev) begin
                     if (last_rise >= 0)
                        check((s == 0) ? "R2" : "R3", "rise-to-rise clocks", i - last_rise, p);
                     last_rise = i;
                  end
                  prev = smp;
               end
               tick(1, 2'd2, 8'(dv & 3), "R8");
               idle(3, "R8");
            end
         end
      end

      // double buffering and spare address (R7, R9)
      psel = 2'd0;
      tick(1, 2'd0, 8'd3, "R7");
      tick(1, 2'd1, 8'd1, "R7");
      tick(1, 2'd2, 8'd1, "R7");
      tick(1, 2'd2, 8'd5, "R7");
      idle(20, "R7");
      tick(1, 2'd1, 8'd2, "R7");
      idle(16, "R7");
      tick(1, 2'd2, 8'd7, "R7");
      idle(40, "R7");
      tick(1, 2'd3, 8'hFF, "R9");
      idle(36, "R9");
      tick(1, 2'd2, 8'd0, "R8");
      idle(4, "R8");
      tick(1, 2'd3, 8'h04, "R9");
      idle(40, "R9");
      finish_run();
   end
endmodule